// File: doc/BRIEF.md
# Chained Wide Timer

This block builds one wide up/down counter from a row of identical 16-bit timer stages. Stage 0 counts the system clock through a programmable divider. Every later stage can be put into an external-clock mode. In that mode it advances once per rising edge of a trigger chosen from another stage's trigger output. The trigger output of each stage is generated from its own wrap (update) event, or from a compare-based waveform. With four stages the concatenated counts form a 64-bit time value. Fewer configured stages give 32 or 48 bits.

Each stage is set up through a write port that selects a stage and a register. To start the chain cleanly, software loads the dividers, reload values and counts, configures the links, and then enables the stages from the most significant down to stage 0. A carry that reaches a disabled stage is dropped. Each stage has a two-state controller. ST_OFF moves to ST_RUN on the *start* transition, which is a control write with the enable bit set. ST_RUN returns to ST_OFF on the *stop* transition, which is a control write with the enable bit clear. ST_RUN also returns to ST_OFF on the *one-pulse finish* transition, which is a wrap while one-pulse mode is set and no control write happens in the same cycle.

Top module: `timer_chain`

## Requirements
- R1: After reset every stage is in ST_OFF with count 0, divider 0, reload 0xFFFF, compare 0, no trigger source and internal-clock counting, so `count_o` and `trig_o` are all zero.
- R2: A stage advances its count once every (divider + 1) counting ticks. The divider is register 3. In count-source code 000, which is register 2 bits [2:0], every clock is a tick.
- R3: With trigger source 010 (update), set in register 1 bits [2:0], a stage pulses its trigger output in the cycle after it wraps. A stage in count-source code 111 advances on the next clock after the rising edge of its selected trigger, so a carry climbs one stage per cycle.
- R4: Control register 0 bit 1 set makes a stage count down. Stepping below 0 loads the reload value and counts as a wrap.
- R5: Control register 0 bit 2 set (one-pulse) returns the stage to ST_OFF at its first wrap, and no further counts follow.
- R6: Counting up past the reload value (register 4) wraps the count to 0 and raises the update event.
- R7: A stage in ST_OFF holds its count and ignores trigger edges, so a carry sent to it is lost.
- R8: Trigger-select value n, in register 2 bits [6:4], routes stage n-1 to the stage, and 0 selects nothing. Count-source codes other than 000 and 111 stop counting.
- R9: Trigger source 000 keeps the stage's trigger output low, so no carry leaves it.
- R10: Trigger source 100 drives the trigger from the compare waveform. The compare mode is register 1 bits [6:4], where 110 means high while count < compare (register 6) and 111 means high while count >= compare. With compare 0xFFFF and mode 110, each up-wrap gives one carry. With compare 0 it gives none.
- R11: A write to the count (register 5) loads it on the next clock, overrides any step in that cycle and clears the stage's divider phase.
- R12: Each update-mode trigger pulse lasts exactly one clock per wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_stage | input | STG_W | Stage addressed by the write |
| wr_addr | input | 3 | Register addressed: 0 ctrl, 1 trigger-out, 2 count-source, 3 divider, 4 reload, 5 count, 6 compare |
| wr_data | input | CNT_W | Write data |
| count_o | output | N_STAGES*CNT_W | Concatenated counts, stage 0 in the low bits |
| trig_o | output | N_STAGES | Trigger output of each stage |

## Verification
A stage stuck in the wrong run state, or a lost trigger edge, shows up at the ports as a wrong field in `count_o`. The bench lets the chain settle a few cycles after stage 0 stops and then checks it, so a missed or doubled carry is caught at the next check. A trigger pulse that is stretched or repeated shows in the per-run count of high cycles on `trig_o[0]`. A wrong divider phase or reload compare moves the low field of `count_o` away from the value computed from the tick count of that run.

// File: rtl/tmr_chain_pkg.sv
package tmr_chain_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_TRGOUT = 3'd1,
        REG_CSRC   = 3'd2,
        REG_DIV    = 3'd3,
        REG_TOP    = 3'd4,
        REG_COUNT  = 3'd5,
        REG_MATCH  = 3'd6
    } reg_sel_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;

    localparam logic [2:0] MM_NONE   = 3'b000;
    localparam logic [2:0] MM_UPDATE = 3'b010;
    localparam logic [2:0] MM_CMP    = 3'b100;

    localparam logic [2:0] SM_CLOCK  = 3'b000;
    localparam logic [2:0] SM_EXTCLK = 3'b111;

    localparam logic [2:0] OC_LOW_BELOW  = 3'b110;
    localparam logic [2:0] OC_HIGH_ABOVE = 3'b111;

endpackage

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          clr,
    input  logic [CW-1:0] div,
    output logic          step
);
    logic [CW-1:0] pc_q;

    assign step = run && tick && !clr && (pc_q >= div);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (clr) begin
            pc_q <= '0;
        end else if (run && tick) begin
            pc_q <= (pc_q >= div) ? '0 : pc_q + 1'b1;
        end
    end

    AST_DIV_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !clr && (pc_q < div)) |=> (pc_q == CW'($past(pc_q) + 1'b1)))
        else $error("divider phase did not advance"); // R2

endmodule

// File: rtl/tc_trig_sel.sv
module tc_trig_sel #(
    parameter int N = 4
) (
    input  logic [N-1:0] trig_bus,
    input  logic [2:0]   sel,
    output logic         trig
);
    always_comb begin
        trig = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (32'(sel) == k + 1) trig = trig_bus[k];
        end
    end
endmodule

// File: rtl/tc_stage.sv
module tc_stage
    import tmr_chain_pkg::*;
#(
    parameter int CW = 16,
    parameter int N  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [N-1:0]  trig_bus,
    output logic [CW-1:0] count,
    output logic          trig_out
);
    run_state_e    state_q, state_d;
    logic          dir_q, opm_q;
    logic [2:0]    mm_q, ocm_q, sm_q, ts_q;
    logic [CW-1:0] div_q, top_q, cmp_q, cnt_q, cnt_d;
    logic          trig_in, trig_in_d, trig_q, trig_d;
    logic          tick, step, upd, ref_nxt, running;
    logic          hit_ctrl, hit_trgout, hit_csrc, hit_div, hit_top, hit_count, hit_match;

    assign hit_ctrl   = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL);
    assign hit_trgout = wr_en && (reg_sel_e'(wr_addr) == REG_TRGOUT);
    assign hit_csrc   = wr_en && (reg_sel_e'(wr_addr) == REG_CSRC);
    assign hit_div    = wr_en && (reg_sel_e'(wr_addr) == REG_DIV);
    assign hit_top    = wr_en && (reg_sel_e'(wr_addr) == REG_TOP);
    assign hit_count  = wr_en && (reg_sel_e'(wr_addr) == REG_COUNT);
    assign hit_match  = wr_en && (reg_sel_e'(wr_addr) == REG_MATCH);

    assign running = (state_q == ST_RUN);

    tc_trig_sel #(.N(N)) u_sel (
        .trig_bus (trig_bus),
        .sel      (ts_q),
        .trig     (trig_in)
    );

    always_comb begin
        unique case (sm_q)
            SM_CLOCK:  tick = 1'b1;
            SM_EXTCLK: tick = trig_in && !trig_in_d;
            default:   tick = 1'b0;
        endcase
    end

    tc_prescaler #(.CW(CW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .tick  (tick),
        .clr   (hit_count),
        .div   (div_q),
        .step  (step)
    );

    // count datapath
    always_comb begin
        cnt_d = cnt_q;
        upd   = 1'b0;
        if (hit_count) begin
            cnt_d = wr_data;
        end else if (step) begin
            if (!dir_q) begin
                if (cnt_q >= top_q) begin
                    cnt_d = '0;
                    upd   = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == '0) begin
                    cnt_d = top_q;
                    upd   = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (hit_ctrl && wr_data[0]) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (hit_ctrl)            state_d = wr_data[0] ? ST_RUN : ST_OFF;
                else if (upd && opm_q)   state_d = ST_OFF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // trigger output generation
    always_comb begin
        unique case (ocm_q)
            OC_LOW_BELOW:  ref_nxt = (cnt_d < cmp_q);
            OC_HIGH_ABOVE: ref_nxt = (cnt_d >= cmp_q);
            default:       ref_nxt = 1'b0;
        endcase
        unique case (mm_q)
            MM_UPDATE: trig_d = upd;
            MM_CMP:    trig_d = ref_nxt;
            default:   trig_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= 1'b0;
            opm_q     <= 1'b0;
            mm_q      <= MM_NONE;
            ocm_q     <= 3'b000;
            sm_q      <= SM_CLOCK;
            ts_q      <= 3'b000;
            div_q     <= '0;
            top_q     <= '1;
            cmp_q     <= '0;
            cnt_q     <= '0;
            trig_in_d <= 1'b0;
            trig_q    <= 1'b0;
        end else begin
            trig_in_d <= trig_in;
            trig_q    <= trig_d;
            cnt_q     <= cnt_d;
            if (hit_ctrl) begin
                dir_q <= wr_data[1];
                opm_q <= wr_data[2];
            end
            if (hit_trgout) begin
                mm_q  <= wr_data[2:0];
                ocm_q <= wr_data[6:4];
            end
            if (hit_csrc) begin
                sm_q <= wr_data[2:0];
                ts_q <= wr_data[6:4];
            end
            if (hit_div)   div_q <= wr_data;
            if (hit_top)   top_q <= wr_data;
            if (hit_match) cmp_q <= wr_data;
        end
    end

    assign count    = cnt_q;
    assign trig_out = trig_q;

    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count |=> (cnt_q == $past(wr_data)))
        else $error("count write not applied"); // R11

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !hit_count) |=> (cnt_q == $past(cnt_q)))
        else $error("stopped stage moved"); // R7

    AST_ONE_PULSE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && opm_q && upd && !hit_ctrl) |=> (state_q == ST_OFF))
        else $error("one-pulse stage kept running"); // R5

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !dir_q && (cnt_q < top_q)) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)))
        else $error("up step wrong"); // R2

    AST_TRIG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && ($past(mm_q) == MM_UPDATE) && !$past(dir_q)) |-> (cnt_q == '0))
        else $error("update trigger without wrap"); // R3

endmodule

// File: rtl/timer_chain.sv
module timer_chain
    import tmr_chain_pkg::*;
#(
    parameter  int N_STAGES = 4,
    parameter  int CNT_W    = 16,
    localparam int STG_W    = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [STG_W-1:0]          wr_stage,
    input  logic [2:0]                wr_addr,
    input  logic [CNT_W-1:0]          wr_data,
    output logic [N_STAGES*CNT_W-1:0] count_o,
    output logic [N_STAGES-1:0]       trig_o
);
    logic [N_STAGES-1:0] trig_bus;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        logic stage_wr;
        assign stage_wr = wr_en && (wr_stage == STG_W'(i));

        tc_stage #(.CW(CNT_W), .N(N_STAGES)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (stage_wr),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .trig_bus (trig_bus),
            .count    (count_o[i*CNT_W +: CNT_W]),
            .trig_out (trig_bus[i])
        );
    end

    assign trig_o = trig_bus;

endmodule

// File: tb/tb_timer_chain.sv
module tb_timer_chain;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_stage;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [63:0] count_o;
    logic [3:0]  trig_o;

    always #5 clk = ~clk;

    timer_chain dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_stage (wr_stage),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .count_o  (count_o),
        .trig_o   (trig_o)
    );

    typedef struct {
        bit          is_trig;
        logic [63:0] val;
        string       req;
    } item_t;

    item_t       sb_q[$];
    item_t       cur;
    int          n_chk = 0;
    int          n_fail = 0;
    int          trig_hits = 0;
    logic [63:0] act;
    logic [2:0]  ctl = 3'b000;
    bit          done = 1'b0;

    // monitor: pops expected items and compares with the ports
    always @(negedge clk) begin
        if (rst_n === 1'b1 && trig_o[0] === 1'b1) trig_hits++;
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            act = cur.is_trig ? 64'(trig_hits) : count_o;
            n_chk++;
            if (act !== cur.val) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", cur.req, act, cur.val);
            end
        end
    end

    task automatic expect_v(input bit t, input logic [63:0] v, input string r);
        repeat (6) @(posedge clk);
        sb_q.push_back('{is_trig: t, val: v, req: r});
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [2:0] a, input logic [15:0] d);
        #1;
        wr_en    = 1'b1;
        wr_stage = s;
        wr_addr  = a;
        wr_data  = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // enable stage 0 for exactly n counting clocks
    task automatic run(input int n);
        wr(2'd0, 3'd0, {13'd0, ctl} | 16'd1);
        repeat (n - 1) @(posedge clk);
        wr(2'd0, 3'd0, {13'd0, ctl});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_stage = '0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        expect_v(0, 64'h0, "R1 reset count");
        expect_v(1, 64'h0, "R1 reset trigger");

        // link stages 1..3, enable from the top down
        for (int i = 3; i >= 1; i--) begin
            wr(2'(i), 3'd1, 16'h0002);
            wr(2'(i), 3'd2, 16'(((i) << 4) | 7));
        end
        for (int i = 3; i >= 1; i--) wr(2'(i), 3'd0, 16'h0001);
        wr(2'd0, 3'd1, 16'h0002);
        wr(2'd0, 3'd3, 16'd4);

        // R2: divide by 5, 23 clocks -> 4 steps
        trig_hits = 0;
        run(23);
        expect_v(0, 64'h0000_0000_0000_0004, "R2 divider");

        // R3: carry ripples through all stages
        wr(2'd0, 3'd3, 16'd0);
        wr(2'd0, 3'd5, 16'hFFFE);
        wr(2'd1, 3'd5, 16'hFFFF);
        wr(2'd2, 3'd5, 16'hFFFF);
        wr(2'd3, 3'd5, 16'h1234);
        trig_hits = 0;
        run(5);
        expect_v(0, 64'h1235_0000_0000_0003, "R3 chained carry");
        expect_v(1, 64'd1, "R12 one trigger cycle per wrap");

        // R11: count write while running overrides the step
        wr(2'd0, 3'd0, 16'h0001);
        repeat (3) @(posedge clk);
        wr(2'd0, 3'd5, 16'h0100);
        repeat (4) @(posedge clk);
        wr(2'd0, 3'd0, 16'h0000);
        expect_v(0, 64'h1235_0000_0000_0105, "R11 count write");

        // R4: down count underflow
        ctl = 3'b010;
        wr(2'd0, 3'd5, 16'd2);
        run(3);
        ctl = 3'b000;
        expect_v(0, 64'h1235_0000_0001_FFFF, "R4 down count");

        // R6: reload 9
        wr(2'd0, 3'd4, 16'd9);
        wr(2'd0, 3'd5, 16'd0);
        trig_hits = 0;
        run(25);
        expect_v(0, 64'h1235_0000_0003_0005, "R6 reload wrap");
        expect_v(1, 64'd2, "R12 pulse per reload wrap");
        wr(2'd0, 3'd4, 16'hFFFF);

        // R5: one-pulse stops at the wrap
        ctl = 3'b100;
        wr(2'd0, 3'd5, 16'hFFFD);
        run(10);
        ctl = 3'b000;
        expect_v(0, 64'h1235_0000_0004_0000, "R5 one-pulse");

        // R7: disabled stage drops the carry
        wr(2'd1, 3'd0, 16'h0000);
        wr(2'd0, 3'd5, 16'hFFFF);
        run(2);
        expect_v(0, 64'h1235_0000_0004_0001, "R7 carry to stopped stage");
        wr(2'd1, 3'd0, 16'h0001);

        // R8: unsupported count source, then select 0, then stage 2 on stage 0
        wr(2'd1, 3'd2, 16'h0013);
        wr(2'd0, 3'd5, 16'hFFFF);
        run(2);
        expect_v(0, 64'h1235_0000_0004_0001, "R8 count source code 011");
        wr(2'd1, 3'd2, 16'h0007);
        wr(2'd2, 3'd2, 16'h0017);
        wr(2'd0, 3'd5, 16'hFFFF);
        run(2);
        expect_v(0, 64'h1235_0001_0004_0001, "R8 select routing");
        wr(2'd1, 3'd2, 16'h0017);
        wr(2'd2, 3'd2, 16'h0027);

        // R9: no trigger source
        wr(2'd0, 3'd1, 16'h0000);
        wr(2'd0, 3'd5, 16'hFFFF);
        trig_hits = 0;
        run(2);
        expect_v(0, 64'h1235_0001_0004_0001, "R9 no carry out");
        expect_v(1, 64'd0, "R9 trigger stays low");
        wr(2'd0, 3'd1, 16'h0002);

        // R10: compare-waveform trigger
        wr(2'd0, 3'd6, 16'hFFFF);
        wr(2'd0, 3'd5, 16'hFFFF);
        wr(2'd0, 3'd1, 16'h0064);
        run(3);
        expect_v(0, 64'h1235_0001_0005_0002, "R10 compare FFFF carries");
        wr(2'd0, 3'd6, 16'h0000);
        wr(2'd0, 3'd5, 16'hFFFF);
        run(3);
        expect_v(0, 64'h1235_0001_0005_0002, "R10 compare 0 no carry");
        wr(2'd0, 3'd1, 16'h0002);

        repeat (3) @(posedge clk);
        done = 1'b1;
        summary();
    end
endmodule